// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block sits at the front of a configuration engine. It accepts 32-bit configuration words over a valid/ready handshake and ignores all of them until it sees the synchronisation word. Once aligned, it reads the packet structure. Each word is treated as a filler, a short header, a long-count header or a payload word. Payload words go out on a register-write port, tagged with the address of the register the header targeted.

Writes to the command register are turned into single-cycle action pulses and are not stored. Writes to the check register are passed to an external comparator port. The decoder keeps a small local copy of a mask register and of a control register that is written through that mask. Bulk frame data is announced in two steps. First a short header with a zero count names the frame-data register. Then a long header carries a 27-bit word count. The decoder counts those words and pulses when the last one is accepted.

Top module: `cfg_pkt_decoder`

## Requirements
- R1: After reset the decoder hunts for the sync word 0xAA995566. Before that word is accepted, every word is consumed (in_ready high), no register write, check or done output fires, and `aligned` stays low. `aligned` goes high after the sync word.
- R2: When aligned, the filler word 0x20000000 (packet type 001, opcode 00) is consumed with no write, no pulse and no change of state. Runs of fillers may appear between packets.
- R3: Header fields: bits [31:29] are the packet type (001 short, 010 long) and bits [28:27] are the opcode (10 write, 00 filler). On a short header, bits [17:13] give the register address and bits [10:0] give the payload word count. Register addresses are: check 0, frame address 1, frame data 2, command 4, control 5, mask 6. Each payload word of a short write with a nonzero count appears on reg_wr_valid with reg_wr_addr set to that address.
- R4: A short write with count 0 must be followed at once by a long header (type 010, opcode 10). Its bits [26:0] give the payload count, and the payload is routed to the short header's address. `frame_done` is high in the cycle the last of those words is accepted, and only then.
- R5: A long header with count 0 raises `frame_done` in the cycle that header is accepted, and no payload word follows.
- R6: A payload word accepted at the command address raises exactly one pulse, for one cycle, in the cycle after acceptance: 0x1 cmd_write_cfg, 0x3 cmd_hold_release, 0x5 cmd_start, 0x9 cmd_clk_switch, 0xA cmd_restore, 0xD cmd_desync. Any other value raises no pulse.
- R7: After the desync command, `aligned` drops together with the cmd_desync pulse. Words that follow produce no register write until a new sync word is accepted.
- R8: A payload word accepted at the check address drives crc_valid high in the same cycle, with crc_value equal to that word.
- R9: A mask write replaces mask_value. A control write sets ctl_value to (old & ~mask) | (new & mask), using the mask in force at that time.
- R10: A long header that does not directly follow a zero-count short write, a word after a zero-count short write that is not a long header, or any unknown packet type or opcode, sets err_flag. err_flag then stays set until reset, and the decoder returns to the hunt state.
- R11: in_ready is low only while reg_wr_valid is high and reg_wr_ready is low. Counts advance only on accepted words, so a stall neither drops nor repeats a payload word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Input configuration word |
| in_ready | output | 1 | Decoder can accept the word |
| reg_wr_valid | output | 1 | Payload word offered to the register-write port |
| reg_wr_ready | input | 1 | Register-write port accepts |
| reg_wr_addr | output | 5 | Target register address |
| reg_wr_data | output | 32 | Payload word |
| crc_valid | output | 1 | Check value presented |
| crc_value | output | 32 | Check value for the external comparator |
| frame_done | output | 1 | Last counted frame word accepted |
| cmd_write_cfg | output | 1 | Write-configuration command pulse |
| cmd_hold_release | output | 1 | Release global hold command pulse |
| cmd_start | output | 1 | Start sequence command pulse |
| cmd_clk_switch | output | 1 | Clock frequency switch command pulse |
| cmd_restore | output | 1 | Restore-state command pulse |
| cmd_desync | output | 1 | Desynchronise command pulse |
| aligned | output | 1 | Sync word seen, packets being decoded |
| err_flag | output | 1 | Sticky framing error |
| mask_value | output | 32 | Local copy of the mask register |
| ctl_value | output | 32 | Local copy of the control register |

## Verification
The hardest condition to reach from the ports is a register-write stall that lands in the middle of a counted payload. A dropped or repeated word there is only visible later, when the packet ends one word early or late. The bench holds reg_wr_ready low for several cycles while a payload word is waiting. It checks that the word and its address stay presented, then releases the stall and sends a filler. The filler must be taken as a header and not as a payload, which proves the count advanced exactly once. Leaving the aligned state again, through desync or through a framing error, is also driven on purpose. In each case the bench checks that words which would otherwise be valid payload produce nothing until a new sync word arrives.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = 27;
    localparam int SCNT_W   = 11;
    localparam int NCMD     = 6;

    localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;

    localparam logic [ADDR_W-1:0] RA_CHECK = 5'd0;
    localparam logic [ADDR_W-1:0] RA_FADDR = 5'd1;
    localparam logic [ADDR_W-1:0] RA_FDATA = 5'd2;
    localparam logic [ADDR_W-1:0] RA_CMD   = 5'd4;
    localparam logic [ADDR_W-1:0] RA_CTL   = 5'd5;
    localparam logic [ADDR_W-1:0] RA_MASK  = 5'd6;

    // command codes, index = pulse bit
    localparam logic [NCMD-1:0][WORD_W-1:0] CMD_CODE = {
        32'h0000000D, 32'h0000000A, 32'h00000009,
        32'h00000005, 32'h00000003, 32'h00000001};
    localparam int CMD_DESYNC_IDX = 5;

    typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_T2WAIT, ST_DATA} dec_st_e;
    typedef enum logic [1:0] {HK_NOP, HK_SHORT, HK_LONG, HK_BAD} hdr_kind_e;

    typedef struct packed {
        hdr_kind_e          kind;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
    } hdr_info_t;

    typedef struct packed {
        dec_st_e            st;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   left;
        logic               long_pkt;
        logic               err;
        logic [NCMD-1:0]    pulse;
    } dec_state_t;

    typedef struct packed {
        logic [WORD_W-1:0]  mask;
        logic [WORD_W-1:0]  ctl;
    } shadow_t;

endpackage

// File: rtl/cfgd_hdr_classify.sv
module cfgd_hdr_classify
    import cfgd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output hdr_info_t         info_o
);
    always_comb begin
        info_o.kind = HK_BAD;
        info_o.addr = word_i[17:13];
        info_o.cnt  = '0;
        unique case (word_i[31:29])
            3'b001: begin
                if (word_i[28:27] == 2'b00) begin
                    info_o.kind = HK_NOP;
                end else if (word_i[28:27] == 2'b10) begin
                    info_o.kind = HK_SHORT;
                    info_o.cnt  = {{(CNT_W-SCNT_W){1'b0}}, word_i[SCNT_W-1:0]};
                end
            end
            3'b010: begin
                if (word_i[28:27] == 2'b10) begin
                    info_o.kind = HK_LONG;
                    info_o.cnt  = word_i[CNT_W-1:0];
                end
            end
            default: info_o.kind = HK_BAD;
        endcase
    end
endmodule

// File: rtl/cfgd_cmd_decode.sv
module cfgd_cmd_decode
    import cfgd_pkg::*;
(
    input  logic              fire_i,
    input  logic [WORD_W-1:0] value_i,
    output logic [NCMD-1:0]   hit_o
);
    for (genvar g = 0; g < NCMD; g++) begin : g_cmd
        assign hit_o[g] = fire_i && (value_i == CMD_CODE[g]);
    end
endmodule

// File: rtl/cfgd_shadow_regs.sv
module cfgd_shadow_regs
    import cfgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] ctl_o
);
    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en_i && addr_i == RA_MASK) begin
            sh_d.mask = data_i;
        end
        if (wr_en_i && addr_i == RA_CTL) begin
            sh_d.ctl = (sh_q.ctl & ~sh_q.mask) | (data_i & sh_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign mask_o = sh_q.mask;
    assign ctl_o  = sh_q.ctl;
endmodule

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder
    import cfgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    output logic              in_ready,
    output logic              reg_wr_valid,
    input  logic              reg_wr_ready,
    output logic [4:0]        reg_wr_addr,
    output logic [31:0]       reg_wr_data,
    output logic              crc_valid,
    output logic [31:0]       crc_value,
    output logic              frame_done,
    output logic              cmd_write_cfg,
    output logic              cmd_hold_release,
    output logic              cmd_start,
    output logic              cmd_clk_switch,
    output logic              cmd_restore,
    output logic              cmd_desync,
    output logic              aligned,
    output logic              err_flag,
    output logic [31:0]       mask_value,
    output logic [31:0]       ctl_value
);
    dec_state_t q, d;
    hdr_info_t  hdr;
    logic       acc, wr_acc, cmd_fire;
    logic [NCMD-1:0] cmd_hit;

    cfgd_hdr_classify i_hdr (.word_i(in_word), .info_o(hdr));

    cfgd_cmd_decode i_cmd (.fire_i(cmd_fire), .value_i(in_word), .hit_o(cmd_hit));

    cfgd_shadow_regs i_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_acc), .addr_i(q.addr),
        .data_i(in_word), .mask_o(mask_value), .ctl_o(ctl_value));

    always_comb begin
        in_ready     = !(q.st == ST_DATA && !reg_wr_ready);
        reg_wr_valid = in_valid && (q.st == ST_DATA);
        reg_wr_addr  = q.addr;
        reg_wr_data  = in_word;
        acc          = in_valid && in_ready;
        wr_acc       = reg_wr_valid && reg_wr_ready;
        cmd_fire     = wr_acc && (q.addr == RA_CMD);
        crc_valid    = wr_acc && (q.addr == RA_CHECK);
        crc_value    = in_word;
        frame_done   = 1'b0;

        d       = q;
        d.pulse = '0;
        unique case (q.st)
            ST_HUNT: begin
                if (acc && in_word == SYNC_WORD) d.st = ST_HDR;
            end
            ST_HDR: begin
                if (acc) begin
                    unique case (hdr.kind)
                        HK_NOP: ;
                        HK_SHORT: begin
                            d.addr     = hdr.addr;
                            d.left     = hdr.cnt;
                            d.long_pkt = 1'b0;
                            d.st       = (hdr.cnt == '0) ? ST_T2WAIT : ST_DATA;
                        end
                        default: begin
                            d.err = 1'b1;
                            d.st  = ST_HUNT;
                        end
                    endcase
                end
            end
            ST_T2WAIT: begin
                if (acc) begin
                    if (hdr.kind == HK_LONG) begin
                        d.long_pkt = 1'b1;
                        d.left     = hdr.cnt;
                        if (hdr.cnt == '0) begin
                            frame_done = 1'b1;
                            d.st       = ST_HDR;
                        end else begin
                            d.st = ST_DATA;
                        end
                    end else begin
                        d.err = 1'b1;
                        d.st  = ST_HUNT;
                    end
                end
            end
            default: begin
                if (wr_acc) begin
                    d.left  = q.left - 1'b1;
                    d.pulse = cmd_hit;
                    if (q.left == CNT_W'(1)) begin
                        d.st       = ST_HDR;
                        frame_done = q.long_pkt;
                    end
                    if (cmd_hit[CMD_DESYNC_IDX]) d.st = ST_HUNT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_HUNT, default: '0};
        else        q <= d;
    end

    assign aligned          = (q.st != ST_HUNT);
    assign err_flag         = q.err;
    assign cmd_write_cfg    = q.pulse[0];
    assign cmd_hold_release = q.pulse[1];
    assign cmd_start        = q.pulse[2];
    assign cmd_clk_switch   = q.pulse[3];
    assign cmd_restore      = q.pulse[4];
    assign cmd_desync       = q.pulse[5];
endmodule

// File: rtl/cfg_pkt_decoder_chk.sv
module cfg_pkt_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        reg_wr_valid,
    input logic        reg_wr_ready,
    input logic [4:0]  reg_wr_addr,
    input logic        crc_valid,
    input logic        frame_done,
    input logic        cmd_write_cfg,
    input logic        cmd_hold_release,
    input logic        cmd_start,
    input logic        cmd_clk_switch,
    input logic        cmd_restore,
    input logic        cmd_desync,
    input logic        aligned,
    input logic        err_flag,
    input logic [31:0] mask_value
);
    p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (!reg_wr_valid && !frame_done && !crc_valid));

    p_cmd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_write_cfg, cmd_hold_release, cmd_start,
                  cmd_clk_switch, cmd_restore, cmd_desync}));

    p_desync_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_desync |-> !aligned);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && !reg_wr_ready) |-> !in_ready);

    p_done_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (in_valid && in_ready));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_valid && reg_wr_ready && reg_wr_addr == 5'd6) |=> $stable(mask_value));

    p_check_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> (reg_wr_valid && reg_wr_ready && reg_wr_addr == 5'd0));
endmodule

bind cfg_pkt_decoder cfg_pkt_decoder_chk i_chk (.*);

// File: tb/test_cfg_pkt_decoder.sv
module test_cfg_pkt_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        reg_wr_valid;
    logic        reg_wr_ready = 1'b1;
    logic [4:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        crc_valid;
    logic [31:0] crc_value;
    logic        frame_done;
    logic        cmd_write_cfg, cmd_hold_release, cmd_start;
    logic        cmd_clk_switch, cmd_restore, cmd_desync;
    logic        aligned, err_flag;
    logic [31:0] mask_value, ctl_value;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] cap;   // {wv, addr(5), done, crc}
    logic [31:0] cap_crc;

    always #10 clk = ~clk;

    cfg_pkt_decoder i_cfg_pkt_decoder (.*);

    // word, expected {wr_valid, addr, done, crc}
    localparam int NV = 21;
    localparam logic [39:0] VEC [NV] = '{
        {32'h12345678, 1'b0, 5'd0, 1'b0, 1'b0},  // R1 hunt
        {32'hAA995566, 1'b0, 5'd0, 1'b0, 1'b0},  // R1 sync
        {32'h20000000, 1'b0, 5'd0, 1'b0, 1'b0},  // R2 filler
        {32'h3000C001, 1'b0, 5'd0, 1'b0, 1'b0},  // R3 mask header
        {32'h00000008, 1'b1, 5'd6, 1'b0, 1'b0},
        {32'h30002001, 1'b0, 5'd0, 1'b0, 1'b0},  // R3 frame addr
        {32'h00000000, 1'b1, 5'd1, 1'b0, 1'b0},
        {32'h30004000, 1'b0, 5'd0, 1'b0, 1'b0},  // R4 zero-count short
        {32'h50000003, 1'b0, 5'd0, 1'b0, 1'b0},  // R4 long count 3
        {32'h11111111, 1'b1, 5'd2, 1'b0, 1'b0},
        {32'h22222222, 1'b1, 5'd2, 1'b0, 1'b0},
        {32'h33333333, 1'b1, 5'd2, 1'b1, 1'b0},  // R4 done on last
        {32'h20000000, 1'b0, 5'd0, 1'b0, 1'b0},  // R2
        {32'h30000001, 1'b0, 5'd0, 1'b0, 1'b0},  // R8 check header
        {32'h0000DEFC, 1'b1, 5'd0, 1'b0, 1'b1},
        {32'h30004000, 1'b0, 5'd0, 1'b0, 1'b0},  // R5
        {32'h50000000, 1'b0, 5'd0, 1'b1, 1'b0},  // R5 zero long count
        {32'h20000000, 1'b0, 5'd0, 1'b0, 1'b0},
        {32'h3000A002, 1'b0, 5'd0, 1'b0, 1'b0},  // R3 two-word control
        {32'hFFFFFFFF, 1'b1, 5'd5, 1'b0, 1'b0},
        {32'h00000000, 1'b1, 5'd5, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        cap     = {reg_wr_valid, reg_wr_valid ? reg_wr_addr : 5'd0, frame_done, crc_valid};
        cap_crc = crc_value;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    function automatic logic [5:0] cmds();
        return {cmd_write_cfg, cmd_hold_release, cmd_start,
                cmd_clk_switch, cmd_restore, cmd_desync};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // reset state
        chk("R1 reset aligned", aligned, 0);
        chk("R10 reset err", err_flag, 0);
        chk("R11 reset ready", in_ready, 1);
        chk("R9 reset mask", mask_value, 0);
        chk("R9 reset ctl", ctl_value, 0);
        chk("R6 reset cmds", cmds(), 0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][39:8]);
            chk($sformatf("R3 vector %0d", i), cap, VEC[i][7:0]);
            if (VEC[i][0]) chk("R8 check value", cap_crc, VEC[i][39:8]);
        end
        idle();
        chk("R1 aligned after sync", aligned, 1);
        chk("R9 mask after write", mask_value, 32'h8);
        chk("R9 ctl through mask 8", ctl_value, 32'h0);

        // R9 masked control writes
        xfer(32'h3000C001); xfer(32'h0000000F);
        xfer(32'h3000A001); xfer(32'hABCDEF55);
        idle();
        chk("R9 mask F", mask_value, 32'hF);
        chk("R9 ctl low nibble", ctl_value, 32'h5);
        xfer(32'h3000C001); xfer(32'h000000F0);
        xfer(32'h3000A001); xfer(32'h000000A0);
        idle();
        chk("R9 ctl keeps unmasked", ctl_value, 32'hA5);

        // R6 command pulses
        begin
            logic [31:0] codes [6] = '{32'h1, 32'h3, 32'h5, 32'h9, 32'hA, 32'h7};
            logic [5:0]  expv  [6] = '{6'b100000, 6'b010000, 6'b001000,
                                       6'b000100, 6'b000010, 6'b000000};
            for (int k = 0; k < 6; k++) begin
                xfer(32'h30008001);
                xfer(codes[k]);
                chk($sformatf("R6 accept cycle code %h", codes[k]), cmds(), 0);
                idle();
                chk($sformatf("R6 pulse code %h", codes[k]), cmds(), expv[k]);
                idle();
                chk("R6 pulse one cycle", cmds(), 0);
            end
        end

        // R11 back-pressure
        xfer(32'h30002002);
        @(negedge clk);
        in_valid = 1'b1; in_word = 32'hCAFE0001; reg_wr_ready = 1'b0;
        #1;
        chk("R11 ready low in stall", {in_ready, reg_wr_valid}, 2'b01);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R11 word held", {in_ready, reg_wr_valid, reg_wr_addr, reg_wr_data},
            {1'b0, 1'b1, 5'd1, 32'hCAFE0001});
        reg_wr_ready = 1'b1;
        #1;
        chk("R11 ready back", in_ready, 1);
        @(posedge clk);
        xfer(32'hCAFE0002);
        chk("R11 second word", cap, {1'b1, 5'd1, 2'b00});
        xfer(32'h20000000);
        chk("R11 no duplicate", cap, 8'h00);

        // R7 desync
        xfer(32'h30008001); xfer(32'h0000000D);
        idle();
        chk("R7 desync pulse and hunt", {cmd_desync, aligned}, 2'b10);
        xfer(32'h30002001);
        chk("R7 ignored header", cap, 8'h00);
        xfer(32'h12345678);
        chk("R7 ignored payload", cap, 8'h00);
        xfer(32'hAA995566);
        idle();
        chk("R7 realigned", aligned, 1);

        // R10 errors
        xfer(32'h50000004);
        idle();
        chk("R10 orphan long header", {err_flag, aligned}, 2'b10);
        xfer(32'h30002001);
        chk("R10 ignored after error", cap, 8'h00);
        xfer(32'hAA995566);
        xfer(32'h30002001);
        xfer(32'h00000001);
        chk("R10 works after resync", cap, {1'b1, 5'd1, 2'b00});
        idle();
        chk("R10 err sticky", err_flag, 1);
        do_reset();
        chk("R10 reset clears err", err_flag, 0);
        xfer(32'hAA995566);
        xfer(32'hE0000000);
        idle();
        chk("R10 unknown type", {err_flag, aligned}, 2'b10);
        do_reset();
        xfer(32'hAA995566);
        xfer(32'h30004000);
        xfer(32'h20000000);
        idle();
        chk("R10 missing long header", {err_flag, aligned}, 2'b10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule